// File: doc/BRIEF.md
# Pipelined Burst SRAM With Zero Bus Turnaround

This block is a synchronous 36-bit-wide memory whose data bus never needs an idle cycle between reads and writes. Every enabled clock edge accepts exactly one command slot. A slot can be a new read, a new write, the next beat of a running burst, or a deselect. Read data leaves the pipeline two clocks after its address. Write data is taken from the input bus two clocks after its address, so a read and a write aimed at the same cycle never compete for the bus.

The storage is split into two banks, and the most significant address bit chooses between them. Each word is four 9-bit byte lanes: two 18-bit halves, each with 16 data bits and 2 parity bits. Each lane has its own write strobe. A burst runs over four beats. The two low address bits step either in linear order (count up, wrapping modulo 4) or in interleaved order (XOR with the beat number). The higher address bits stay fixed for the whole burst.

A read may follow a write to the same word before that write has reached the array. In that case a lane-wise bypass returns the newer data. The output enable is combinational and overrides the pipeline. The clock enable freezes every stage.

Top module: `nbl_sram`

## Requirements
- R1: After reset, `dout_vld` is 0 and `dout` is 0. A continuation slot (`adv_ld`=1) issued before any load is a deselect.
- R2: Consider a load slot (`adv_ld`=0) with every bit of `cs` at 1 and `wr_en`=0. After the second enabled edge that follows it, the block drives the stored word on `dout` with `dout_vld`=1.
- R3: Consider a selected load slot with `wr_en`=1. The block samples `din` at the second enabled edge after the address edge. It writes lane i (bits 9i+8..9i) only where `lane_wr[i]`=1.
- R4: A load slot with any `cs` bit at 0 is a deselect. A deselect writes nothing, and `dout_vld` is 0 in its output slot. Continuation slots that follow a deselect are deselects as well.
- R5: With `burst_mode`=0 sampled at the load, beat k of a burst (k=0..3) uses low bits (base+k) mod 4. The upper bits stay unchanged.
- R6: With `burst_mode`=1 sampled at the load, beat k uses low bits base XOR k. The mode input is ignored on continuation beats.
- R7: On every beat of a burst write, `lane_wr` of that beat selects the lanes that beat writes.
- R8: Reads and writes may alternate on consecutive slots. A read always returns the word as written by every earlier slot, with lanes merged from a write that has not yet committed.
- R9: While `out_en`=0, `dout_vld` is 0 and `dout` is 0 in the same cycle. When `out_en` returns to 1, the pipelined value reappears.
- R10: While `clk_en`=0, no stage advances. The outputs hold, nothing is captured, and nothing is written.
- R11: The top address bit selects the bank. Words that differ only in that bit are stored independently.
- R12: A burst continued past four beats wraps, so beat 4 reuses the beat-0 address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| clk_en | input | 1 | 1 = stages advance on this edge |
| adv_ld | input | 1 | 0 = load new command, 1 = continue burst |
| wr_en | input | 1 | 1 = write, 0 = read (load slots only) |
| lane_wr | input | 4 | Per-lane write strobes, active high |
| cs | input | 3 | Chip selects, all must be 1 to select |
| burst_mode | input | 1 | 0 = linear, 1 = interleaved order |
| addr | input | 6 | Word address, bit 5 picks the bank |
| out_en | input | 1 | Combinational output enable |
| din | input | 36 | Write data, two clocks behind its address |
| dout | output | 36 | Read data, 0 when not driven |
| dout_vld | output | 1 | 1 = `dout` carries read data |

## Verification
The collision that matters most is a write and a read of the same word in adjacent slots. At the edge where the read samples the array, the write is committing its data. The bench provokes this for all sixteen lane masks, and again across both banks. It judges the result against a plain sequential memory model, updated in issue order. Burst address generation and deselects are computed independently in the bench. Frozen cycles with hostile inputs are placed between a write address and its data, to show that the freeze and the delayed write sampling do not interfere.

// File: rtl/nbl_pkg.sv
`timescale 1ns/1ps
package nbl_pkg;

   localparam int BEAT_BITS = 2;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_ord_e;

   // Low address bits for a given beat of a burst.
   function automatic logic [BEAT_BITS-1:0] beat_lo(
      input logic [BEAT_BITS-1:0] base,
      input logic [BEAT_BITS-1:0] beat,
      input burst_ord_e           ord
   );
      logic [BEAT_BITS-1:0] r;
      if (ord == ORD_INTERLEAVE) r = base ^ beat;
      else                       r = base + beat;
      return r;
   endfunction

endpackage

// File: rtl/nbl_ctrl.sv
`timescale 1ns/1ps
module nbl_ctrl
   import nbl_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int NUM_CS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              adv_ld,
   input  logic              wr_en,
   input  logic [LANES-1:0]  lane_wr,
   input  logic [NUM_CS-1:0] cs,
   input  logic              burst_mode,
   input  logic [ADDR_W-1:0] addr,
   output logic              s1_vld,
   output logic              s1_wr,
   output logic [ADDR_W-1:0] s1_addr,
   output logic              s2_vld,
   output logic              s2_wr,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [LANES-1:0]  s2_lanes
);

   localparam int UP_W = ADDR_W - BEAT_BITS;

   // burst context
   logic [ADDR_W-1:0]    base_q;
   logic [BEAT_BITS-1:0] beat_q;
   logic                 wr_q;
   logic                 act_q;
   burst_ord_e           ord_q;

   logic [LANES-1:0]     s1_lanes;

   // next slot
   logic                 nx_vld;
   logic                 nx_wr;
   logic [ADDR_W-1:0]    nx_addr;
   logic [BEAT_BITS-1:0] nx_beat;
   logic                 selected;

   assign selected = &cs;

   always_comb begin
      if (!adv_ld) begin
         nx_vld  = selected;
         nx_wr   = wr_en;
         nx_addr = addr;
         nx_beat = '0;
      end else begin
         nx_vld  = act_q;
         nx_wr   = wr_q;
         nx_beat = beat_q + 1'b1;
         nx_addr = {base_q[ADDR_W-1:BEAT_BITS],
                    beat_lo(base_q[BEAT_BITS-1:0], nx_beat, ord_q)};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         beat_q   <= '0;
         wr_q     <= 1'b0;
         act_q    <= 1'b0;
         ord_q    <= ORD_LINEAR;
         s1_vld   <= 1'b0;
         s1_wr    <= 1'b0;
         s1_addr  <= '0;
         s1_lanes <= '0;
         s2_vld   <= 1'b0;
         s2_wr    <= 1'b0;
         s2_addr  <= '0;
         s2_lanes <= '0;
      end else if (clk_en) begin
         if (!adv_ld) begin
            base_q <= addr;
            act_q  <= selected;
            wr_q   <= wr_en;
            ord_q  <= burst_ord_e'(burst_mode);
         end
         beat_q   <= nx_beat;
         s1_vld   <= nx_vld;
         s1_wr    <= nx_wr;
         s1_addr  <= nx_addr;
         s1_lanes <= lane_wr;
         s2_vld   <= s1_vld;
         s2_wr    <= s1_wr;
         s2_addr  <= s1_addr;
         s2_lanes <= s1_lanes;
      end
   end

   // R4: a load with any chip select low yields an invalid slot
   p_desel_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !adv_ld && !(&cs)) |=> !s1_vld);

   // R4: continuing a deselected slot stays deselected
   p_desel_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv_ld && !s1_vld) |=> !s1_vld);

   // R5: upper address bits do not move during a burst
   p_burst_upper_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv_ld) |=> (s1_addr[ADDR_W-1:BEAT_BITS] ==
                              $past(s1_addr[ADDR_W-1:BEAT_BITS])));

   logic unused_up;
   assign unused_up = (UP_W > 0);

endmodule

// File: rtl/nbl_bank.sv
`timescale 1ns/1ps
module nbl_bank #(
   parameter int ROW_W  = 5,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    clk_en,
   input  logic                    wr_en,
   input  logic [ROW_W-1:0]        wr_row,
   input  logic [LANES-1:0]        wr_lanes,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic [ROW_W-1:0]        rd_row,
   output logic [LANES*LANE_W-1:0] rd_data
);

   localparam int DW    = LANES * LANE_W;
   localparam int DEPTH = 1 << ROW_W;

   logic [DW-1:0] mem [DEPTH];

   // lane-masked write, registered read (old data on same-edge collision)
   always_ff @(posedge clk) begin
      if (clk_en) begin
         for (int i = 0; i < LANES; i++) begin
            if (wr_en && wr_lanes[i])
               mem[wr_row][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
         end
         rd_data <= mem[rd_row];
      end
   end

endmodule

// File: rtl/nbl_outpath.sv
`timescale 1ns/1ps
module nbl_outpath #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clk_en,
   input  logic                      s1_vld,
   input  logic                      s1_wr,
   input  logic [ADDR_W-1:0]         s1_addr,
   input  logic                      s2_vld,
   input  logic                      s2_wr,
   input  logic [ADDR_W-1:0]         s2_addr,
   input  logic [LANES-1:0]          s2_lanes,
   input  logic [LANES*LANE_W-1:0]   din,
   input  logic [2*LANES*LANE_W-1:0] bank_q,
   input  logic                      out_en,
   output logic [LANES*LANE_W-1:0]   dout,
   output logic                      dout_vld
);

   localparam int DW = LANES * LANE_W;

   logic [LANES-1:0] hit_q;
   logic [DW-1:0]    byp_q;
   logic             bsel_q;
   logic [DW-1:0]    dout_q;
   logic             rdv_q;
   logic [DW-1:0]    arr_word;
   logic [DW-1:0]    merged;
   logic             same_word;

   assign same_word = s1_vld && !s1_wr && s2_vld && s2_wr && (s1_addr == s2_addr);
   assign arr_word  = bsel_q ? bank_q[2*DW-1:DW] : bank_q[DW-1:0];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[i*LANE_W +: LANE_W] = hit_q[i] ? byp_q[i*LANE_W +: LANE_W]
                                                   : arr_word[i*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q  <= '0;
         byp_q  <= '0;
         bsel_q <= 1'b0;
         dout_q <= '0;
         rdv_q  <= 1'b0;
      end else if (clk_en) begin
         hit_q  <= {LANES{same_word}} & s2_lanes;
         byp_q  <= din;
         bsel_q <= s1_addr[ADDR_W-1];
         dout_q <= merged;
         rdv_q  <= s2_vld && !s2_wr;
      end
   end

   assign dout_vld = out_en && rdv_q;
   assign dout     = dout_vld ? dout_q : '0;

   // R2: a read leaving stage two is presented on the next edge
   p_rd_latency_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && s2_vld && !s2_wr && out_en) |=> (rdv_q));

   // R3: a write slot never shows up as read data
   p_wr_noout_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && s2_vld && s2_wr) |=> !dout_vld);

   // R10: a frozen edge leaves the output stage untouched
   p_freeze_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(rdv_q) && $stable(dout_q)));

endmodule

// File: rtl/nbl_sram.sv
`timescale 1ns/1ps
module nbl_sram #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int NUM_CS = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en,
   input  logic                    adv_ld,
   input  logic                    wr_en,
   input  logic [LANES-1:0]        lane_wr,
   input  logic [NUM_CS-1:0]       cs,
   input  logic                    burst_mode,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    out_en,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_vld
);

   localparam int DW    = LANES * LANE_W;
   localparam int ROW_W = ADDR_W - 1;
   localparam int BANKS = 2;

   if (ADDR_W < 3) begin : g_chk_aw
      $error("ADDR_W must cover bank bit and two burst bits");
   end
   if ((LANES % 2) != 0) begin : g_chk_lanes
      $error("LANES must split into two equal halves");
   end
   if (NUM_CS < 1) begin : g_chk_cs
      $error("at least one chip select is required");
   end

   logic              s1_vld, s1_wr, s2_vld, s2_wr;
   logic [ADDR_W-1:0] s1_addr, s2_addr;
   logic [LANES-1:0]  s2_lanes;
   logic [BANKS-1:0]  bank_we;
   logic [BANKS*DW-1:0] bank_q;

   nbl_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .NUM_CS(NUM_CS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_ld(adv_ld),
      .wr_en(wr_en), .lane_wr(lane_wr), .cs(cs), .burst_mode(burst_mode),
      .addr(addr),
      .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr),
      .s2_vld(s2_vld), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_lanes(s2_lanes)
   );

   for (genvar g = 0; g < BANKS; g++) begin : g_bank
      assign bank_we[g] = s2_vld && s2_wr && (s2_addr[ADDR_W-1] == g[0]);
      nbl_bank #(.ROW_W(ROW_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank (
         .clk(clk), .clk_en(clk_en),
         .wr_en(bank_we[g]), .wr_row(s2_addr[ROW_W-1:0]),
         .wr_lanes(s2_lanes), .wr_data(din),
         .rd_row(s1_addr[ROW_W-1:0]),
         .rd_data(bank_q[g*DW +: DW])
      );
   end

   nbl_outpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_out (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
      .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr),
      .s2_vld(s2_vld), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_lanes(s2_lanes),
      .din(din), .bank_q(bank_q), .out_en(out_en),
      .dout(dout), .dout_vld(dout_vld)
   );

   // R11: a committing write touches one bank only
   p_one_bank_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we));

endmodule

// File: tb/nbl_sram_test.sv
`timescale 1ns/1ps
module nbl_sram_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en = 1'b1;
   logic        adv_ld = 1'b1;
   logic        wr_en = 1'b0;
   logic [3:0]  lane_wr = 4'h0;
   logic [2:0]  cs = 3'b000;
   logic        burst_mode = 1'b0;
   logic [5:0]  addr = '0;
   logic        out_en = 1'b1;
   logic [35:0] din = '0;
   logic [35:0] dout;
   logic        dout_vld;

   always #4 clk = ~clk;

   nbl_sram uut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_ld(adv_ld),
      .wr_en(wr_en), .lane_wr(lane_wr), .cs(cs), .burst_mode(burst_mode),
      .addr(addr), .out_en(out_en), .din(din), .dout(dout), .dout_vld(dout_vld)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model
   logic [35:0] ref_mem [64];
   bit          sl_v   [4096];
   bit          sl_w   [4096];
   int          sl_a   [4096];
   logic [3:0]  sl_l   [4096];
   string       sl_t   [4096];
   int          n = 0;
   int          b_base = 0, b_beat = 0;
   bit          b_wr = 0, b_act = 0, b_md = 0;
   logic [35:0] last_dout = '0;
   bit          last_vld = 0;

   function automatic logic [35:0] wdata(int k);
      longint v;
      v = (longint'(k) + 1) * 64'd2654435761 ^ (longint'(k) << 19);
      return v[35:0];
   endfunction

   task automatic chk(bit ok, string tag, logic [36:0] act, logic [36:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(bit adv, bit wr, int a, logic [3:0] ln, logic [2:0] c,
                       bit md, string tag);
      int ia, lo, k;
      logic [35:0] exp, wd;
      if (!adv) begin
         b_act = (c == 3'b111); b_base = a; b_beat = 0; b_wr = wr; b_md = md;
         ia = a;
      end else begin
         b_beat = (b_beat + 1) % 4;
         lo = b_md ? ((b_base % 4) ^ b_beat) : (((b_base % 4) + b_beat) % 4);
         ia = (b_base / 4) * 4 + lo;
      end
      sl_v[n] = b_act; sl_w[n] = b_wr; sl_a[n] = ia; sl_l[n] = ln; sl_t[n] = tag;
      @(negedge clk);
      clk_en = 1'b1; adv_ld = adv; wr_en = wr; lane_wr = ln; cs = c;
      burst_mode = md; addr = 6'(a);
      if (n >= 2 && sl_v[n-2] && sl_w[n-2]) din = wdata(n-2);
      else din = ~wdata(n + 1000);
      @(posedge clk); #1;
      k = n - 2;
      if (k >= 0) begin
         if (sl_v[k] && !sl_w[k]) begin
            exp = ref_mem[sl_a[k]];
            chk(dout_vld === 1'b1 && dout === exp, sl_t[k], {dout_vld, dout}, {1'b1, exp});
         end else begin
            chk(dout_vld === 1'b0 && dout === '0, sl_t[k], {dout_vld, dout}, 37'd0);
         end
         if (sl_v[k] && sl_w[k]) begin
            wd = wdata(k);
            for (int i = 0; i < 4; i++)
               if (sl_l[k][i]) ref_mem[sl_a[k]][i*9 +: 9] = wd[i*9 +: 9];
         end
      end
      last_dout = dout; last_vld = dout_vld;
      n++;
   endtask

   task automatic idle(string tag);
      step(1'b0, 1'b0, 0, 4'h0, 3'b000, 1'b0, tag);
   endtask

   task automatic freeze();
      @(negedge clk);
      clk_en = 1'b0; adv_ld = 1'b0; wr_en = 1'b1; cs = 3'b111; addr = 6'd13;
      lane_wr = 4'hF; din = 36'hF_FFFF_FFFF; burst_mode = 1'b1;
      @(posedge clk); #1;
      // R10: frozen edge leaves outputs unchanged
      chk(dout_vld === last_vld && dout === last_dout, "R10",
          {dout_vld, dout}, {last_vld, last_dout});
   endtask

   task automatic oe_probe();
      out_en = 1'b0; #1;
      chk(dout_vld === 1'b0 && dout === '0, "R9", {dout_vld, dout}, 37'd0);
      out_en = 1'b1; #1;
      chk(dout_vld === last_vld && dout === last_dout, "R9",
          {dout_vld, dout}, {last_vld, last_dout});
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) ref_mem[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk(dout_vld === 1'b0 && dout === '0, "R1", {dout_vld, dout}, 37'd0);
      // R1: continuation before any load is a deselect
      step(1'b1, 1'b1, 0, 4'hF, 3'b111, 1'b0, "R1");
      step(1'b1, 1'b0, 0, 4'hF, 3'b111, 1'b0, "R1");

      // R3: fill every word, then R2/R11 read every word back
      for (int a = 0; a < 64; a++) step(1'b0, 1'b1, a, 4'hF, 3'b111, 1'b0, "R3");
      for (int a = 0; a < 64; a++)
         step(1'b0, 1'b0, a, 4'h0, 3'b111, 1'b0, (a >= 32) ? "R11" : "R2");

      // R3/R8: every lane mask, read right behind the write (bypass)
      for (int m = 0; m < 16; m++) begin
         step(1'b0, 1'b1, 9, 4'(m), 3'b111, 1'b0, "R3");
         step(1'b0, 1'b0, 9, 4'h0, 3'b111, 1'b0, "R8");
         step(1'b0, 1'b0, 41, 4'h0, 3'b111, 1'b0, "R11");
      end

      // R8: dense read/write mixes across banks
      for (int a = 0; a < 16; a++) begin
         step(1'b0, 1'b1, a + 16, 4'(a), 3'b111, 1'b0, "R8");
         step(1'b0, 1'b0, a + 16, 4'h0, 3'b111, 1'b0, "R8");
         step(1'b0, 1'b1, a + 48, 4'(~a), 3'b111, 1'b0, "R8");
         step(1'b0, 1'b0, a + 16, 4'h0, 3'b111, 1'b0, "R8");
         step(1'b0, 1'b0, a + 48, 4'h0, 3'b111, 1'b0, "R11");
      end

      // R5/R6: bursts from every start in both orders
      for (int md = 0; md < 2; md++) begin
         for (int s = 0; s < 4; s++) begin
            step(1'b0, 1'b1, 40 + s, 4'hF, 3'b111, md[0], md ? "R6" : "R5");
            for (int b = 1; b < 4; b++)
               step(1'b1, 1'b0, 0, 4'hF, 3'b111, ~md[0], md ? "R6" : "R5");
            step(1'b0, 1'b0, 40 + s, 4'h0, 3'b111, md[0], md ? "R6" : "R5");
            for (int b = 1; b < 4; b++)
               step(1'b1, 1'b1, 0, 4'h0, 3'b111, ~md[0], md ? "R6" : "R5");
            for (int b = 0; b < 4; b++)
               step(1'b0, 1'b0, 40 + b, 4'h0, 3'b111, 1'b0, md ? "R6" : "R5");
         end
      end

      // R7: burst write with per-beat lane masks
      step(1'b0, 1'b1, 22, 4'b0001, 3'b111, 1'b1, "R7");
      step(1'b1, 1'b0, 0, 4'b0110, 3'b111, 1'b0, "R7");
      step(1'b1, 1'b0, 0, 4'b0000, 3'b111, 1'b0, "R7");
      step(1'b1, 1'b0, 0, 4'b1000, 3'b111, 1'b0, "R7");
      for (int b = 20; b < 24; b++) step(1'b0, 1'b0, b, 4'h0, 3'b111, 1'b0, "R7");

      // R12: burst continued past four beats wraps
      step(1'b0, 1'b0, 45, 4'h0, 3'b111, 1'b0, "R12");
      for (int b = 1; b < 7; b++) step(1'b1, 1'b0, 0, 4'h0, 3'b111, 1'b0, "R12");
      step(1'b0, 1'b1, 58, 4'hF, 3'b111, 1'b1, "R12");
      for (int b = 1; b < 6; b++) step(1'b1, 1'b0, 0, 4'hF, 3'b111, 1'b0, "R12");
      for (int b = 56; b < 60; b++) step(1'b0, 1'b0, b, 4'h0, 3'b111, 1'b0, "R12");

      // R4: every partial chip-select pattern deselects
      for (int c = 0; c < 7; c++) begin
         step(1'b0, 1'b1, 20, 4'hF, 3'(c), 1'b0, "R4");
         step(1'b1, 1'b1, 0, 4'hF, 3'b111, 1'b0, "R4");
         step(1'b0, 1'b0, 20, 4'h0, 3'b111, 1'b0, "R4");
         step(1'b0, 1'b0, 21, 4'h0, 3'b111, 1'b0, "R4");
      end

      // R9: output enable override
      step(1'b0, 1'b0, 7, 4'h0, 3'b111, 1'b0, "R9");
      idle("R9");
      step(1'b0, 1'b0, 39, 4'h0, 3'b111, 1'b0, "R9");
      oe_probe();
      idle("R9");
      oe_probe();

      // R10: freezes between write address and write data
      step(1'b0, 1'b1, 50, 4'b1010, 3'b111, 1'b0, "R10");
      freeze();
      freeze();
      step(1'b0, 1'b0, 50, 4'h0, 3'b111, 1'b0, "R10");
      freeze();
      step(1'b0, 1'b0, 13, 4'h0, 3'b111, 1'b0, "R10");
      freeze();
      step(1'b0, 1'b0, 50, 4'h0, 3'b111, 1'b0, "R10");
      freeze();
      idle("R10");
      idle("R10");
      idle("R10");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule